// File: doc/BRIEF.md
# Dual-Write-Port Register File with Instruction-Driven Port Selection

This block stores eight 32-bit program registers and the decode logic that addresses them. Each cycle it takes a 4-bit opcode and the two register fields of the instruction (`ra`, `rb`). From these it derives four register IDs: two read sources (A and B) and two write destinations (E, which carries the arithmetic result, and M, which carries the memory result). Some opcodes use the stack-pointer register without naming it in a field. Any ID with bit 3 set, such as the reserved value 8, means the port does nothing.

Reads are combinational. They return the contents held before the coming clock edge, so an instruction that reads and writes the same register sees the old value. Both writes take effect together on the rising edge. If both write ports name the same register, the memory-result port wins. A synchronous, active-high reset clears every register to zero.

Opcode values used throughout: 0 idle, 1 stop, 2 register move, 3 immediate move, 4 store, 5 load, 6 arithmetic, 7 branch, 8 subroutine call, 9 subroutine return, A stack push, B stack pop, C–F unassigned. The stack pointer is register 6.

Top module: `rf_dual_write`

## Requirements
- R1: One cycle after `rst` is sampled high, all eight registers read as zero on both read ports.
- R2: The port A source is `ra` for opcodes 2, 4, 6 and A. It is register 6 for opcodes 9 and B. For every other opcode it is ID 8.
- R3: The port B source is `rb` for opcodes 4, 5 and 6. It is register 6 for opcodes 8, 9, A and B. For every other opcode it is ID 8.
- R4: The port E destination is `rb` for opcodes 2, 3 and 6. It is register 6 for opcodes 8, 9, A and B. For every other opcode it is ID 8. The selected register takes `wdata_e` at the rising edge.
- R5: The port M destination is `ra` for opcodes 5 and B. For every other opcode it is ID 8. The selected register takes `wdata_m` at the rising edge.
- R6: A read port whose ID has bit 3 set (8 to 15) outputs zero. A write port whose ID has bit 3 set changes no register.
- R7: When ports E and M name the same register in one cycle, that register takes `wdata_m`.
- R8: Read outputs follow the inputs combinationally and show the register contents from before the edge, even when the same register is written at that edge.
- R9: Opcodes 0, 1, 7 and C–F write no register, whatever the values of `ra`, `rb` and the write data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset that clears all registers |
| opcode | input | 4 | Instruction opcode that drives port selection |
| ra | input | 4 | First register field of the instruction |
| rb | input | 4 | Second register field of the instruction |
| wdata_e | input | 32 | Write data for destination port E |
| wdata_m | input | 32 | Write data for destination port M |
| rdata_a | output | 32 | Combinational read data, port A |
| rdata_b | output | 32 | Combinational read data, port B |

## Verification
The bound checker watches the internally selected IDs on every cycle. It confirms that a reset leaves zeros, that a no-access read gives zero, and that an E or M write appears when the same register is read in the next cycle. It also confirms that M beats E on a collision, and that the read data stays still when neither the inputs nor the register contents change. The opcode-to-ID mapping itself is visible only at the ports. It therefore rests on the bench, which runs every opcode with directed and random fields against its own register model. That model also covers unassigned opcodes and stack-pointer collisions, the cases the checker cannot tell apart from legal traffic.

// File: rtl/regfile_pkg.sv
package regfile_pkg;

    localparam int NREG    = 8;
    localparam int REG_W   = 32;
    localparam int IDX_W   = $clog2(NREG);
    localparam int ID_W    = IDX_W + 1;

    localparam logic [ID_W-1:0] ID_NONE = ID_W'(1) << IDX_W;
    localparam logic [ID_W-1:0] ID_SP   = ID_W'(6);

    typedef enum logic [3:0] {
        OP_IDLE  = 4'h0,
        OP_STOP  = 4'h1,
        OP_MOVRR = 4'h2,
        OP_MOVIR = 4'h3,
        OP_STORE = 4'h4,
        OP_LOAD  = 4'h5,
        OP_ARITH = 4'h6,
        OP_BRNCH = 4'h7,
        OP_CALL  = 4'h8,
        OP_RETN  = 4'h9,
        OP_PUSH  = 4'hA,
        OP_POP   = 4'hB
    } op_e;

    typedef struct packed {
        logic [ID_W-1:0] src_a;
        logic [ID_W-1:0] src_b;
        logic [ID_W-1:0] dst_e;
        logic [ID_W-1:0] dst_m;
    } port_ids_t;

    function automatic logic id_is_none(input logic [ID_W-1:0] id);
        return id[IDX_W];
    endfunction

    function automatic logic id_hits(input logic [ID_W-1:0] id, input int idx);
        return !id[IDX_W] && (id[IDX_W-1:0] == IDX_W'(idx));
    endfunction

endpackage

// File: rtl/rf_port_select.sv
module rf_port_select
    import regfile_pkg::*;
(
    input  logic [3:0]      opcode,
    input  logic [ID_W-1:0] ra,
    input  logic [ID_W-1:0] rb,
    output port_ids_t       ids
);

    op_e op;
    assign op = op_e'(opcode);

    always_comb begin
        ids.src_a = ID_NONE;
        ids.src_b = ID_NONE;
        ids.dst_e = ID_NONE;
        ids.dst_m = ID_NONE;

        case (op)
            OP_MOVRR, OP_STORE, OP_ARITH, OP_PUSH: ids.src_a = ra;
            OP_POP, OP_RETN:                        ids.src_a = ID_SP;
            default:                                ids.src_a = ID_NONE;
        endcase

        case (op)
            OP_STORE, OP_LOAD, OP_ARITH:             ids.src_b = rb;
            OP_PUSH, OP_POP, OP_CALL, OP_RETN:       ids.src_b = ID_SP;
            default:                                 ids.src_b = ID_NONE;
        endcase

        case (op)
            OP_MOVRR, OP_MOVIR, OP_ARITH:            ids.dst_e = rb;
            OP_PUSH, OP_POP, OP_CALL, OP_RETN:       ids.dst_e = ID_SP;
            default:                                 ids.dst_e = ID_NONE;
        endcase

        case (op)
            OP_LOAD, OP_POP:                         ids.dst_m = ra;
            default:                                 ids.dst_m = ID_NONE;
        endcase
    end

endmodule

// File: rtl/rf_storage.sv
module rf_storage
    import regfile_pkg::*;
#(
    parameter int N = NREG,
    parameter int W = REG_W
) (
    input  logic            clk,
    input  logic            rst,
    input  port_ids_t       ids,
    input  logic [W-1:0]    wdata_e,
    input  logic [W-1:0]    wdata_m,
    output logic [W-1:0]    rdata_a,
    output logic [W-1:0]    rdata_b
);

    logic [W-1:0] cells [N];

    for (genvar i = 0; i < N; i++) begin : g_cell
        logic [W-1:0] q;
        logic         hit_e;
        logic         hit_m;

        assign hit_e = id_hits(ids.dst_e, i);
        assign hit_m = id_hits(ids.dst_m, i);

        always_ff @(posedge clk) begin
            if (rst) begin
                q <= '0;
            end else if (hit_m) begin
                q <= wdata_m;
            end else if (hit_e) begin
                q <= wdata_e;
            end
        end

        assign cells[i] = q;
    end

    assign rdata_a = id_is_none(ids.src_a) ? '0 : cells[ids.src_a[IDX_W-1:0]];
    assign rdata_b = id_is_none(ids.src_b) ? '0 : cells[ids.src_b[IDX_W-1:0]];

endmodule

// File: rtl/rf_dual_write.sv
module rf_dual_write
    import regfile_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [3:0]        opcode,
    input  logic [ID_W-1:0]   ra,
    input  logic [ID_W-1:0]   rb,
    input  logic [REG_W-1:0]  wdata_e,
    input  logic [REG_W-1:0]  wdata_m,
    output logic [REG_W-1:0]  rdata_a,
    output logic [REG_W-1:0]  rdata_b
);

    port_ids_t ids;

    rf_port_select u_sel (
        .opcode (opcode),
        .ra     (ra),
        .rb     (rb),
        .ids    (ids)
    );

    rf_storage #(
        .N (NREG),
        .W (REG_W)
    ) u_store (
        .clk     (clk),
        .rst     (rst),
        .ids     (ids),
        .wdata_e (wdata_e),
        .wdata_m (wdata_m),
        .rdata_a (rdata_a),
        .rdata_b (rdata_b)
    );

endmodule

// File: rtl/rf_dual_write_chk.sv
module rf_dual_write_chk
    import regfile_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [3:0]        opcode,
    input  logic [ID_W-1:0]   ra,
    input  logic [ID_W-1:0]   rb,
    input  logic [REG_W-1:0]  wdata_e,
    input  logic [REG_W-1:0]  wdata_m,
    input  logic [REG_W-1:0]  rdata_a,
    input  logic [REG_W-1:0]  rdata_b,
    input  port_ids_t         ids
);

    logic no_write;
    assign no_write = ids.dst_e[IDX_W] && ids.dst_m[IDX_W];

    // R1: after a reset cycle every readable register holds zero
    p_reset_clears_r1: assert property (@(posedge clk)
        $past(rst) |-> (rdata_a == '0 && rdata_b == '0));

    // R6: a no-access read returns zero
    p_none_read_zero_r6: assert property (@(posedge clk) disable iff (rst)
        ids.src_a[IDX_W] |-> rdata_a == '0);

    // R4: an E write, not overridden by M, is seen on the next read of that register
    p_e_write_seen_r4: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(ids.dst_e[IDX_W]) && $past(ids.dst_m) != $past(ids.dst_e)
         && ids.src_a == $past(ids.dst_e)) |-> rdata_a == $past(wdata_e));

    // R5: an M write is seen on the next read of that register
    p_m_write_seen_r5: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(ids.dst_m[IDX_W]) && ids.src_b == $past(ids.dst_m))
        |-> rdata_b == $past(wdata_m));

    // R7: on a collision, the M data is the value kept
    p_m_wins_collision_r7: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(ids.dst_m[IDX_W]) && $past(ids.dst_e) == $past(ids.dst_m)
         && ids.src_a == $past(ids.dst_m)) |-> rdata_a == $past(wdata_m));

    // R8: with steady inputs and no write, the read data does not move
    p_read_steady_r8: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(no_write) && $stable(opcode) && $stable(ra) && $stable(rb))
        |-> ($stable(rdata_a) && $stable(rdata_b)));

endmodule

bind rf_dual_write rf_dual_write_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .opcode  (opcode),
    .ra      (ra),
    .rb      (rb),
    .wdata_e (wdata_e),
    .wdata_m (wdata_m),
    .rdata_a (rdata_a),
    .rdata_b (rdata_b),
    .ids     (ids)
);

// File: tb/tb_rf_dual_write.sv
module tb_rf_dual_write;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  opcode = 4'h0;
    logic [3:0]  ra = 4'h8;
    logic [3:0]  rb = 4'h8;
    logic [31:0] wdata_e = '0;
    logic [31:0] wdata_m = '0;
    logic [31:0] rdata_a;
    logic [31:0] rdata_b;

    int compared = 0;
    int mismatched = 0;
    bit done = 0;
    bit finished = 0;
    logic [31:0] mdl [8];

    always #4 clk = ~clk;

    rf_dual_write dut (
        .clk(clk), .rst(rst), .opcode(opcode), .ra(ra), .rb(rb),
        .wdata_e(wdata_e), .wdata_m(wdata_m), .rdata_a(rdata_a), .rdata_b(rdata_b)
    );

    function automatic int src_a_of(int op, int fa, int fb);
        if (op == 2 || op == 4 || op == 6 || op == 10) return fa;
        if (op == 9 || op == 11) return 6;
        return 8;
    endfunction
    function automatic int src_b_of(int op, int fa, int fb);
        if (op == 4 || op == 5 || op == 6) return fb;
        if (op >= 8 && op <= 11) return 6;
        return 8;
    endfunction
    function automatic int dst_e_of(int op, int fa, int fb);
        if (op == 2 || op == 3 || op == 6) return fb;
        if (op >= 8 && op <= 11) return 6;
        return 8;
    endfunction
    function automatic int dst_m_of(int op, int fa, int fb);
        if (op == 5 || op == 11) return fa;
        return 8;
    endfunction
    function automatic logic [31:0] mread(int id);
        return (id >= 8) ? 32'h0 : mdl[id];
    endfunction

    task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic step(int op, int fa, int fb, logic [31:0] de, logic [31:0] dm,
                        string ta, string tb);
        int de_id, dm_id;
        @(negedge clk);
        opcode = 4'(op); ra = 4'(fa); rb = 4'(fb); wdata_e = de; wdata_m = dm;
        #3;
        check(ta, "port A", rdata_a, mread(src_a_of(op, fa, fb)));
        check(tb, "port B", rdata_b, mread(src_b_of(op, fa, fb)));
        de_id = dst_e_of(op, fa, fb);
        dm_id = dst_m_of(op, fa, fb);
        @(posedge clk);
        if (de_id < 8) mdl[de_id] = de;
        if (dm_id < 8) mdl[dm_id] = dm;
    endtask

    task automatic probe(int r, string tag);
        step(4, r, r, 32'hDEAD0000, 32'hBEEF0000, tag, tag);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog: actual hung expected completion");
            finish_run();
        end
    end

    initial begin
        for (int i = 0; i < 8; i++) mdl[i] = 32'h0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: all registers zero after reset
        for (int i = 0; i < 8; i++) probe(i, "R1");

        // R4: fill registers through E with immediate moves
        for (int i = 0; i < 8; i++) step(3, 8, i, 32'h1000_0000 + 32'(i), 32'h0, "R4", "R4");
        for (int i = 0; i < 8; i++) probe(i, "R4");

        // R5: loads write M to ra
        step(5, 2, 3, 32'h0, 32'h5555_0002, "R5", "R3");
        probe(2, "R5");

        // R2/R3: stack-pointer implicit reads
        step(9, 1, 1, 32'hA0, 32'hB0, "R2", "R3");
        step(10, 4, 0, 32'hC0, 32'hD0, "R2", "R3");
        step(8, 0, 0, 32'hE0, 32'hF0, "R2", "R3");
        probe(6, "R4");

        // R7: pop into the stack pointer, E and M collide
        step(11, 6, 8, 32'h1111_1111, 32'h2222_2222, "R2", "R3");
        probe(6, "R7");
        step(6, 3, 3, 32'h7777_0003, 32'h0, "R7", "R7");
        step(5, 3, 8, 32'h0, 32'h3333_3333, "R5", "R3");
        probe(3, "R7");

        // R6: no-access IDs read zero and write nothing
        step(4, 8, 8, 32'h0, 32'h0, "R6", "R6");
        step(4, 15, 9, 32'h0, 32'h0, "R6", "R6");
        step(2, 1, 8, 32'hFFFF_FFFF, 32'h0, "R2", "R6");
        step(3, 8, 12, 32'hFFFF_FFFF, 32'h0, "R6", "R6");
        step(5, 9, 0, 32'h0, 32'hFFFF_FFFF, "R6", "R3");
        for (int i = 0; i < 8; i++) probe(i, "R6");

        // R8: read and write the same register, old value then new
        step(6, 5, 5, 32'h8888_0005, 32'h0, "R8", "R8");
        probe(5, "R8");
        step(2, 5, 5, 32'h9999_0005, 32'h0, "R8", "R8");
        probe(5, "R8");

        // R9: unassigned opcodes leave every register unchanged
        for (int op = 12; op < 16; op++) step(op, op % 8, (op + 3) % 8, 32'hAAAA_AAAA, 32'hBBBB_BBBB, "R9", "R9");
        step(0, 1, 2, 32'hAAAA_AAAA, 32'hBBBB_BBBB, "R9", "R9");
        step(1, 3, 4, 32'hAAAA_AAAA, 32'hBBBB_BBBB, "R9", "R9");
        step(7, 5, 6, 32'hAAAA_AAAA, 32'hBBBB_BBBB, "R9", "R9");
        for (int i = 0; i < 8; i++) probe(i, "R9");

        // R2/R3/R4/R5/R7: random traffic over all opcodes
        for (int n = 0; n < 600; n++) begin
            step(int'($urandom_range(0, 15)), int'($urandom_range(0, 9)), int'($urandom_range(0, 9)),
                 $urandom, $urandom, "R2", "R3");
        end
        for (int i = 0; i < 8; i++) probe(i, "R4");

        // R1: reset again from a loaded state
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        for (int i = 0; i < 8; i++) mdl[i] = 32'h0;
        @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < 8; i++) probe(i, "R1");

        done = 1;
        finish_run();
    end

endmodule